// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Front End

This block sits on the slave side of an 8-bit microcontroller bus where address and data share the same eight lines. It samples the bus strobes in one internal clock, captures the address when the latch strobe falls, and presents a stable address of up to 17 bits to an internal memory or register space. From the bus strobes it derives a single-cycle write pulse and a read-enable level. It drives read data back onto the shared lines only when a read targets its own address window.

Two address arrangements are supported. In non-page mode the shared lines carry address bits 7:0 and a dedicated 8-bit port carries bits 15:8. In page mode the shared lines carry bits 15:8 and the dedicated port carries bits 7:0. In page mode the latch strobe may be skipped on a page hit: the upper byte is kept and only the low byte follows the dedicated port. A mode input picks the arrangement, and a selection input maps the two control inputs onto program-read and data-read.

Top module: `mcu_bus_demux`

## Requirements
- R1: After reset `mem_addr` is zero, `mem_wr` is low, `ad_oe` is low, and the block is in non-page mode.
- R2: In non-page mode, a falling edge of `ale` updates the whole address: `ad_in` gives bits 7:0, `a_ded` gives bits 15:8 and `a16_in` gives bit 16. The new address is visible three clocks after the edge.
- R3: In page mode, a falling edge of `ale` loads bits 15:8 from `ad_in` and bit 16 from `a16_in`. Address bits 7:0 follow `a_ded` with one clock of delay.
- R4: In page mode, with no latch strobe (a page hit), bits 16:8 keep their last latched value while bits 7:0 still follow `a_ded`.
- R5: With `EXT_A16`=1, bit 16 of the address is taken from `a16_in`. The address window is [`REGION_BASE`, `REGION_BASE`+`REGION_SIZE`), and by default it covers only addresses with bit 16 clear.
- R6: `rd_map` selects the strobe mapping (active-low). With 0 (and 3), `cntl1_n` is program-read and `cntl2_n` is data-read. With 1, `cntl1_n` is the only read and is reported as program-read, and `cntl2_n` has no effect. With 2, `cntl1_n` is data-read and `cntl2_n` is program-read. `mem_prog` is 1 while a program-read is active.
- R7: Each falling edge of `wr_n` gives exactly one cycle of `mem_wr`, three clocks after the edge, carrying `ad_in` as sampled at that time on `mem_wdata`. There is no pulse if the address is outside the window.
- R8: `ad_oe` and `mem_rd` are high only while a read strobe is active and the address is inside the window. `ad_out` equals `mem_rdata` then and is 0 otherwise.
- R9: `lane_odd` equals address bit 0 (1 means the odd byte).
- R10: A change on `page_mode` takes effect only on a clock where the synchronized bus is idle (latch strobe low, all strobes high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| page_mode | input | 1 | 1 selects page mode |
| rd_map | input | 2 | Read-strobe mapping select |
| ale | input | 1 | Address latch strobe, active high |
| ad_in | input | 8 | Shared address/data lines, input side |
| ad_out | output | 8 | Shared lines, read data output |
| ad_oe | output | 1 | Output enable for the shared lines |
| a_ded | input | 8 | Dedicated address byte (high in non-page, low in page mode) |
| a16_in | input | 1 | Extra address bit 16 |
| cntl1_n | input | 1 | Control input 1, active low |
| cntl2_n | input | 1 | Control input 2, active low |
| wr_n | input | 1 | Write strobe, active low |
| mem_addr | output | 17 | Latched internal address |
| mem_rd | output | 1 | Read in progress to the window |
| mem_prog | output | 1 | Active read is a program read |
| mem_rdata | input | 8 | Read data from the internal space |
| mem_wr | output | 1 | One-cycle write pulse |
| mem_wdata | output | 8 | Write data |
| lane_odd | output | 1 | Byte lane: 1 = odd byte |

## Verification
A wrong latched byte appears on `mem_addr` three clocks after the latch strobe falls, or one clock after `a_ded` moves in page mode. The bench compares every clock against a model driven by delayed copies of the inputs, so such an error is caught at once. A wrong mode register shows up on the first page hit as a low byte that stops following `a_ded`, or as one that keeps following it. Mapping or window faults show on `ad_oe`, `mem_prog` and `ad_out` while a strobe is held, and a lost or doubled write shows as a missing or extra `mem_wr` pulse.

// File: rtl/mcu_bus_demux.sv
module mcu_bus_demux #(
  parameter bit          EXT_A16     = 1'b1,
  parameter logic [16:0] REGION_BASE = 17'h00000,
  parameter logic [16:0] REGION_SIZE = 17'h10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        page_mode,
  input  logic [1:0]  rd_map,
  input  logic        ale,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  a_ded,
  input  logic        a16_in,
  input  logic        cntl1_n,
  input  logic        cntl2_n,
  input  logic        wr_n,
  output logic [16:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_prog,
  input  logic [7:0]  mem_rdata,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  output logic        lane_odd
);
  localparam logic [3:0]  SYNC_IDLE = 4'b0111;
  localparam logic [17:0] WIN_LO    = {1'b0, REGION_BASE};
  localparam logic [17:0] WIN_HI    = {1'b0, REGION_BASE} + {1'b0, REGION_SIZE};

  logic [3:0]  s1, s2;
  logic        ale_s3, wr_s3;
  logic        mode_q;
  logic [16:0] addr_q;
  logic        a16_eff;
  logic        ale_fall, wr_fall, bus_idle, hit;
  logic        rd_prog, rd_data;

  generate
    if (EXT_A16) begin : g_a16
      assign a16_eff = a16_in;
    end else begin : g_no_a16
      assign a16_eff = 1'b0;
    end
  endgenerate

  assign ale_fall = ale_s3 & ~s2[3];
  assign wr_fall  = wr_s3 & ~s2[0];
  assign bus_idle = ~s2[3] & s2[2] & s2[1] & s2[0];
  assign hit      = ({1'b0, addr_q} >= WIN_LO) && ({1'b0, addr_q} < WIN_HI);

  always_comb begin
    case (rd_map)
      2'd1:    begin rd_prog = ~s2[2]; rd_data = 1'b0;   end
      2'd2:    begin rd_prog = ~s2[1]; rd_data = ~s2[2]; end
      default: begin rd_prog = ~s2[2]; rd_data = ~s2[1]; end
    endcase
  end

  assign mem_addr = addr_q;
  assign lane_odd = addr_q[0];
  assign mem_prog = rd_prog;
  assign mem_rd   = (rd_prog | rd_data) & hit;
  assign ad_oe    = mem_rd;
  assign ad_out   = mem_rd ? mem_rdata : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1        <= SYNC_IDLE;
      s2        <= SYNC_IDLE;
      ale_s3    <= 1'b0;
      wr_s3     <= 1'b1;
      mode_q    <= 1'b0;
      addr_q    <= '0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      s1     <= {ale, cntl1_n, cntl2_n, wr_n};
      s2     <= s1;
      ale_s3 <= s2[3];
      wr_s3  <= s2[0];
      if (bus_idle) mode_q <= page_mode;
      if (mode_q) begin
        addr_q[7:0] <= a_ded;
        if (ale_fall) addr_q[16:8] <= {a16_eff, ad_in};
      end else if (ale_fall) begin
        addr_q <= {a16_eff, a_ded, ad_in};
      end
      mem_wr <= wr_fall & hit;
      if (wr_fall) mem_wdata <= ad_in;
    end
  end
endmodule

module mcu_bus_demux_chk #(
  parameter logic [16:0] BASE = 17'h00000,
  parameter logic [16:0] SIZE = 17'h10000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_q,
  input logic        ale_fall,
  input logic        bus_idle,
  input logic [7:0]  ad_in,
  input logic [16:0] mem_addr,
  input logic        mem_wr,
  input logic        ad_oe
);
  localparam logic [17:0] LO = {1'b0, BASE};
  localparam logic [17:0] HI = {1'b0, BASE} + {1'b0, SIZE};

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> !mem_wr); // R7
  AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> ({1'b0, mem_addr} >= LO && {1'b0, mem_addr} < HI)); // R8
  AST_PAGE_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !ale_fall) |=> $stable(mem_addr[16:8])); // R4
  AST_NONPAGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && ale_fall) |=> (mem_addr[7:0] == $past(ad_in))); // R2
  AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(bus_idle)); // R10
endmodule

bind mcu_bus_demux mcu_bus_demux_chk #(.BASE(REGION_BASE), .SIZE(REGION_SIZE)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .ale_fall(ale_fall), .bus_idle(bus_idle),
  .ad_in(ad_in), .mem_addr(mem_addr), .mem_wr(mem_wr), .ad_oe(ad_oe)
);

// File: tb/test_mcu_bus_demux.sv
`timescale 1ns/1ps
module test_mcu_bus_demux;
  logic clk = 1'b0, rst_n = 1'b0;
  logic page_mode = 1'b0;
  logic [1:0] rd_map = 2'd0;
  logic ale = 1'b0, a16_in = 1'b0, cntl1_n = 1'b1, cntl2_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = 8'h00, a_ded = 8'h00;
  logic [7:0] ad_out, mem_wdata, mem_rdata;
  logic ad_oe, mem_rd, mem_prog, mem_wr, lane_odd;
  logic [16:0] mem_addr;

  int checks = 0, fails = 0, wcount = 0;
  logic [16:0] last_wa = '0;
  logic [7:0]  last_wd = '0;

  always #4 clk = ~clk;

  function automatic logic [7:0] rdf(logic [16:0] a, logic p);
    return a[7:0] ^ a[15:8] ^ (p ? 8'h5A : 8'h3C);
  endfunction
  function automatic bit in_win(logic [16:0] a);
    return a < 17'h10000;
  endfunction

  assign mem_rdata = rdf(mem_addr, mem_prog);

  mcu_bus_demux i_mcu_bus_demux (
    .clk(clk), .rst_n(rst_n), .page_mode(page_mode), .rd_map(rd_map), .ale(ale),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_ded(a_ded), .a16_in(a16_in),
    .cntl1_n(cntl1_n), .cntl2_n(cntl2_n), .wr_n(wr_n), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_prog(mem_prog), .mem_rdata(mem_rdata), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .lane_odd(lane_odd));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: history of input samples, newest first
  typedef struct packed {
    logic ale, c1, c2, wr, a16, pm;
    logic [7:0] ad, ded;
  } smp_t;
  smp_t hist [4];
  logic [16:0] m_addr;
  logic m_page, m_wr;
  logic [7:0] m_wd;
  localparam smp_t IDLE_SMP = '{ale:1'b0, c1:1'b1, c2:1'b1, wr:1'b1, a16:1'b0, pm:1'b0, ad:8'h00, ded:8'h00};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hist[i] = IDLE_SMP;
      m_addr = '0; m_page = 1'b0; m_wr = 1'b0; m_wd = '0;
    end else begin
      logic [16:0] old_a;
      logic old_p, af, wf, idl;
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = '{ale:ale, c1:cntl1_n, c2:cntl2_n, wr:wr_n, a16:a16_in, pm:page_mode, ad:ad_in, ded:a_ded};
      old_a = m_addr; old_p = m_page;
      af  = hist[3].ale && !hist[2].ale;
      wf  = hist[3].wr && !hist[2].wr;
      idl = !hist[2].ale && hist[2].c1 && hist[2].c2 && hist[2].wr;
      if (old_p) begin
        m_addr[7:0] = hist[0].ded;
        if (af) m_addr[16:8] = {hist[0].a16, hist[0].ad};
      end else if (af) begin
        m_addr = {hist[0].a16, hist[0].ded, hist[0].ad};
      end
      m_wr = wf && in_win(old_a);
      if (wf) m_wd = hist[0].ad;
      if (idl) m_page = hist[0].pm;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic pr, dr, er;
      case (rd_map)
        2'd1:    begin pr = !hist[1].c1; dr = 1'b0; end
        2'd2:    begin pr = !hist[1].c2; dr = !hist[1].c1; end
        default: begin pr = !hist[1].c1; dr = !hist[1].c2; end
      endcase
      er = (pr || dr) && in_win(m_addr);
      chk("R2 R3 R4 R5 R10 mem_addr", 32'(mem_addr), 32'(m_addr));
      chk("R9 lane_odd", 32'(lane_odd), 32'(m_addr[0]));
      chk("R7 mem_wr", 32'(mem_wr), 32'(m_wr));
      if (m_wr) chk("R7 mem_wdata", 32'(mem_wdata), 32'(m_wd));
      chk("R6 mem_prog", 32'(mem_prog), 32'(pr));
      chk("R8 ad_oe", 32'(ad_oe), 32'(er));
      chk("R8 mem_rd", 32'(mem_rd), 32'(er));
      chk("R8 ad_out", 32'(ad_out), 32'(er ? rdf(m_addr, pr) : 8'h00));
      if (mem_wr) begin wcount++; last_wa = mem_addr; last_wd = mem_wdata; end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic latch(logic [7:0] a, logic [7:0] d, logic h);
    ale = 1'b1; ad_in = a; a_ded = d; a16_in = h;
    step(2); ale = 1'b0; step(4);
  endtask
  task automatic do_write(logic [7:0] d);
    ad_in = d; wr_n = 1'b0; step(4); wr_n = 1'b1; step(4);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(5); rst_n = 1'b1; step(1);
    chk("R1 reset addr", 32'(mem_addr), 32'h0);
    chk("R1 reset oe", 32'(ad_oe), 32'h0);
    chk("R1 reset wr", 32'(mem_wr), 32'h0);

    latch(8'h34, 8'h12, 1'b0);
    chk("R2 nonpage addr", 32'(mem_addr), 32'h01234);
    chk("R9 even lane", 32'(lane_odd), 32'h0);
    do_write(8'hA5);
    chk("R7 write count", 32'(wcount), 32'd1);
    chk("R7 write addr", 32'(last_wa), 32'h01234);
    chk("R7 write data", 32'(last_wd), 32'hA5);

    latch(8'h35, 8'h12, 1'b0);
    chk("R9 odd lane", 32'(lane_odd), 32'h1);
    cntl1_n = 1'b0; step(4);
    chk("R8 read oe", 32'(ad_oe), 32'h1);
    chk("R6 map0 cntl1 prog", 32'(mem_prog), 32'h1);
    chk("R8 read data", 32'(ad_out), 32'(rdf(17'h01235, 1'b1)));
    cntl1_n = 1'b1; step(4);
    chk("R8 released", 32'(ad_oe), 32'h0);
    cntl2_n = 1'b0; step(4);
    chk("R6 map0 cntl2 data", 32'(mem_prog), 32'h0);
    cntl2_n = 1'b1; step(4);

    rd_map = 2'd1;
    cntl2_n = 1'b0; step(4);
    chk("R6 map1 cntl2 ignored", 32'(ad_oe), 32'h0);
    cntl2_n = 1'b1; step(4);
    cntl1_n = 1'b0; step(4);
    chk("R6 map1 single read", 32'(mem_prog), 32'h1);
    cntl1_n = 1'b1; step(4);

    rd_map = 2'd2;
    cntl1_n = 1'b0; step(4);
    chk("R6 map2 cntl1 data", 32'(mem_prog), 32'h0);
    chk("R6 map2 oe", 32'(ad_oe), 32'h1);
    cntl1_n = 1'b1; step(4);
    cntl2_n = 1'b0; step(4);
    chk("R6 map2 cntl2 prog", 32'(mem_prog), 32'h1);
    cntl2_n = 1'b1; step(4);
    rd_map = 2'd0;

    latch(8'h00, 8'h00, 1'b1);
    chk("R5 bit16", 32'(mem_addr), 32'h10000);
    cntl1_n = 1'b0; step(4);
    chk("R8 outside window", 32'(ad_oe), 32'h0);
    cntl1_n = 1'b1; step(4);
    do_write(8'h3C);
    chk("R7 no write outside", 32'(wcount), 32'd1);

    page_mode = 1'b1; step(3);
    latch(8'h56, 8'h78, 1'b0);
    chk("R3 page latch", 32'(mem_addr), 32'h05678);
    a_ded = 8'h9A; step(2);
    chk("R4 page hit", 32'(mem_addr), 32'h0569A);

    cntl1_n = 1'b0; step(3);
    page_mode = 1'b0; step(3);
    a_ded = 8'h11; step(2);
    chk("R10 mode held mid-cycle", 32'(mem_addr[7:0]), 32'h11);
    cntl1_n = 1'b1; step(5);
    a_ded = 8'h22; step(2);
    chk("R10 mode applied when idle", 32'(mem_addr[7:0]), 32'h11);

    latch(8'hF0, 8'hAB, 1'b0);
    chk("R2 second nonpage", 32'(mem_addr), 32'h0ABF0);
    page_mode = 1'b1; step(3);
    a_ded = 8'hC3; step(2);
    do_write(8'h77);
    chk("R4 page hit write addr", 32'(last_wa), 32'h0ABC3);
    chk("R7 page write data", 32'(last_wd), 32'h77);
    chk("R7 write count end", 32'(wcount), 32'd2);

    step(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule